// File: doc/BRIEF.md
# Gated Programmable Timer Channel

This block is one counting channel of a timer unit. It holds a mode register and a count register and advances the count from one of two sources. The first is the core clock, passed through a prescaler whose divide ratio is selected in the mode register. The second is an external tick input, which is synchronised inside the block and counted once per rising edge. An external blanking gate, also synchronised, can freeze, clear, start or stop the count in one of four selectable behaviours.

Software loads the mode and count registers through a single-cycle write strobe with a register select. Writing the mode clears the count and restarts the prescaler. Writing the count loads the new value but leaves the prescaler phase alone, so the next increment lands where it would have landed anyway. The channel drives its registered count, its stored mode word and a stopped indication to the interrupt logic, which does target matching elsewhere.

Top module: `gated_timer_channel`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the stored mode is 0 and the channel is running, so the count advances by one on every clock once reset is released.
- R2: With mode bit 8 clear, the count advances once every N clocks, where mode bits [14:13] select N: 00 gives 1, 01 gives 8, 10 gives 16, 11 gives 256. The first increment after a mode write occurs on the N-th rising clock edge after the write edge; the count wraps from all ones to 0.
- R3: With mode bit 8 set, the prescaler is bypassed and the count advances once per rising edge of the tick input; a tick level sampled on clock edge k is acted on at edge k+2.
- R4: A mode write (write strobe with select 0) stores the written word with bit 10 forced to 1, clears the count to 0 and restarts the prescaler phase.
- R5: A mode write with both bit 8 and bit 0 set leaves the channel stopped.
- R6: On the prescaled variant, a mode write whose bits [2:0] equal 3'b111 or 3'b001 leaves the channel stopped; 3'b011 does not.
- R7: A count write (write strobe with select 1) loads the written value on that edge; the prescaler phase is not reset, so the next increment keeps its original spacing from the last mode write.
- R8: With mode bit 0 set and bits [2:1] = 0, a gate start edge freezes the count and stops the channel; a gate end edge clears the count and restarts counting.
- R9: With bit 0 set and bits [2:1] = 1, each gate end edge clears the count to 0 and counting continues; start edges do nothing.
- R10: With bit 0 set and bits [2:1] = 2, a gate start edge clears the count and starts counting; a gate end edge stops the channel holding its count.
- R11: With bit 0 set and bits [2:1] = 3, a start edge does nothing; an end edge clears and starts the channel only if it is stopped.
- R12: Gate start is a rise and gate end a fall of the gate input, seen through a two-flop synchroniser: a gate level sampled on edge k takes effect at edge k+2. With mode bit 0 clear, gate edges have no effect.
- R13: In one cycle, a register write takes precedence over a gate action and over an increment, and a gate clear takes precedence over an increment and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_sel | input | 1 | Register select: 0 mode, 1 count |
| wr_data | input | 16 | Write data |
| gate_in | input | 1 | Asynchronous blanking gate |
| tick_in | input | 1 | Asynchronous external tick source |
| count_o | output | CNT_W | Current count |
| mode_o | output | 16 | Stored mode word |
| stopped_o | output | 1 | Channel is halted |

## Verification
The collisions of interest are a gate action landing on the same edge as a prescaler increment, and a register write landing on the same edge as a gate action. The sweep shifts the gate edges by a configuration-dependent offset against every divide ratio so that gate clears and holds fall on increment edges, and a directed case times a gate end so that its clear arrives on the very edge of a count write. A cycle model in the bench, built from the requirements, judges every cycle, and the directed case expects the written value to survive.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer channel: mode-word bit positions,
// gate behaviour encoding and the prescaler limit decode.
package tmr_pkg;

    localparam int MODE_W    = 16;
    localparam int B_GATE_EN = 0;
    localparam int B_GM_LO   = 1;
    localparam int B_ALT     = 8;
    localparam int B_IRQ     = 10;
    localparam int B_DIV_LO  = 13;
    localparam int MAX_DIV   = 256;
    localparam int PH_W      = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        GM_HALT_ON_START = 2'd0,
        GM_CLEAR_ON_END  = 2'd1,
        GM_WINDOW        = 2'd2,
        GM_RESUME_ON_END = 2'd3
    } gate_mode_e;

    // Terminal phase value for each divide code (ratio minus one).
    function automatic logic [PH_W-1:0] div_limit(input logic [1:0] code);
        case (code)
            2'd0:    div_limit = PH_W'(0);
            2'd1:    div_limit = PH_W'(7);
            2'd2:    div_limit = PH_W'(15);
            default: div_limit = PH_W'(MAX_DIV - 1);
        endcase
    endfunction

endpackage

// File: rtl/tmr_sync.sv
// Two-flop synchroniser with one extra history flop.
// Assumes: async_in may change at any time; lvl_o is the synchronised
// level and prev_o its value one clock earlier, so the parent can derive
// single-cycle edge events from the pair.
module tmr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl_o,
    output logic prev_o
);

    logic s1_q, s2_q, s3_q;

    // Shift the input through the metastability and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o  = s2_q;
    assign prev_o = s3_q;

endmodule

// File: rtl/tmr_prescaler.sv
// Phase counter that divides the core clock by 1, 8, 16 or 256.
// Assumes: restart has priority and returns the phase to zero; the phase
// advances only while run is high; tick_o marks the terminal phase.
// With PRESCALE_EN = 0 the ratio is always 1.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter bit PRESCALE_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] div_code,
    output logic       tick_o
);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;

    // Pick the terminal phase for the selected ratio.
    assign limit  = PRESCALE_EN ? div_limit(div_code) : PH_W'(0);
    assign tick_o = run && (phase_q == limit);

    // Advance the phase, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == limit) ? '0 : phase_q + 1'b1;
        end
    end

    // R2: a terminal phase is never followed by another one unless ratio is 1.
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart && limit != '0 && $stable(limit)) |=> !tick_o);

endmodule

// File: rtl/tmr_gate_ctrl.sv
// Decodes gate start/end events into count and run-state actions.
// Assumes: start_ev and end_ev are single-cycle and never both high;
// outputs are combinational and used by the parent on the same edge.
module tmr_gate_ctrl
    import tmr_pkg::*;
(
    input  logic       en,
    input  gate_mode_e mode,
    input  logic       start_ev,
    input  logic       end_ev,
    input  logic       stopped,
    output logic       clr_o,
    output logic       hold_o,
    output logic       go_o,
    output logic       halt_o
);

    // Map the event and behaviour onto clear, hold, start and stop.
    always_comb begin
        clr_o  = 1'b0;
        hold_o = 1'b0;
        go_o   = 1'b0;
        halt_o = 1'b0;
        if (en) begin
            case (mode)
                GM_HALT_ON_START: begin
                    if (start_ev) begin
                        hold_o = 1'b1;
                        halt_o = 1'b1;
                    end
                    if (end_ev) begin
                        clr_o = 1'b1;
                        go_o  = 1'b1;
                    end
                end
                GM_CLEAR_ON_END: begin
                    if (end_ev) clr_o = 1'b1;
                end
                GM_WINDOW: begin
                    if (start_ev) begin
                        clr_o = 1'b1;
                        go_o  = 1'b1;
                    end
                    if (end_ev) begin
                        hold_o = 1'b1;
                        halt_o = 1'b1;
                    end
                end
                default: begin
                    if (end_ev && stopped) begin
                        clr_o = 1'b1;
                        go_o  = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/gated_timer_channel.sv
// One timer channel: mode and count registers, prescaled or external
// tick source, and four gate behaviours driven by a blanking gate.
// Assumes: CNT_W <= MODE_W; wr_en is a single-cycle strobe; gate_in and
// tick_in are asynchronous and synchronised here.
module gated_timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit PRESCALE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              gate_in,
    input  logic              tick_in,
    output logic [CNT_W-1:0]  count_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              stopped_o
);

    localparam logic [MODE_W-1:0] IRQ_SET = MODE_W'(1) << B_IRQ;

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  count_q;
    logic              stopped_q;

    logic mode_wr, cnt_wr;
    logic g_lvl, g_prev, t_lvl, t_prev;
    logic g_start, g_end, t_rise;
    logic g_clr, g_hold, g_go, g_halt;
    logic alt_src, pre_tick, pre_run, pre_restart, inc;
    logic low_stop, force_stop;
    gate_mode_e gmode;

    assign mode_wr = wr_en && !wr_sel;
    assign cnt_wr  = wr_en &&  wr_sel;
    assign alt_src = mode_q[B_ALT];
    assign gmode   = gate_mode_e'(mode_q[B_GM_LO +: 2]);

    tmr_sync u_gate_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gate_in),
        .lvl_o    (g_lvl),
        .prev_o   (g_prev)
    );

    tmr_sync u_tick_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tick_in),
        .lvl_o    (t_lvl),
        .prev_o   (t_prev)
    );

    assign g_start = g_lvl && !g_prev;
    assign g_end   = !g_lvl && g_prev;
    assign t_rise  = t_lvl && !t_prev;

    tmr_gate_ctrl u_gate_ctrl (
        .en       (mode_q[B_GATE_EN]),
        .mode     (gmode),
        .start_ev (g_start),
        .end_ev   (g_end),
        .stopped  (stopped_q),
        .clr_o    (g_clr),
        .hold_o   (g_hold),
        .go_o     (g_go),
        .halt_o   (g_halt)
    );

    assign pre_run     = !stopped_q && !alt_src;
    assign pre_restart = mode_wr || (g_clr && !wr_en);

    tmr_prescaler #(.PRESCALE_EN(PRESCALE_EN)) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (pre_restart),
        .run      (pre_run),
        .div_code (mode_q[B_DIV_LO +: 2]),
        .tick_o   (pre_tick)
    );

    // Select the increment source for this cycle.
    assign inc = !stopped_q && (alt_src ? t_rise : pre_tick);

    // The prescaled variant refuses gate behaviours 0 and 3 at mode write.
    generate
        if (PRESCALE_EN) begin : g_presc_stop
            assign low_stop = (wr_data[2:0] == 3'b111) || (wr_data[2:0] == 3'b001);
        end else begin : g_plain_stop
            assign low_stop = 1'b0;
        end
    endgenerate

    assign force_stop = (wr_data[B_ALT] && wr_data[B_GATE_EN]) || low_stop;

    // Hold the mode word, flagging the interrupt bit on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= wr_data | IRQ_SET;
    end

    // Update the count: writes first, then gate clear, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (mode_wr)          count_q <= '0;
        else if (cnt_wr)           count_q <= wr_data[CNT_W-1:0];
        else if (g_clr)            count_q <= '0;
        else if (inc && !g_hold)   count_q <= count_q + 1'b1;
    end

    // Track whether the channel is halted.
    always_ff @(posedge clk) begin
        if (!rst_n)       stopped_q <= 1'b0;
        else if (mode_wr) stopped_q <= force_stop;
        else if (cnt_wr)  stopped_q <= stopped_q;
        else if (g_halt)  stopped_q <= 1'b1;
        else if (g_go)    stopped_q <= 1'b0;
    end

    assign count_o   = count_q;
    assign mode_o    = mode_q;
    assign stopped_o = stopped_q;

    p_mode_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (count_q == '0) && (mode_q == ($past(wr_data) | IRQ_SET)));

    p_count_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_q == $past(wr_data[CNT_W-1:0]));

    p_alt_gate_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_data[B_ALT] && wr_data[B_GATE_EN]) |=> stopped_q);

    p_gate_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (g_clr && !wr_en) |=> count_q == '0);

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_q && !wr_en && !g_clr) |=> count_q == $past(count_q));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !g_clr) |=> (count_q == $past(count_q)) ||
                               (count_q == $past(count_q) + 1'b1));

    p_edge_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        g_start |=> !g_start);

    generate
        if (PRESCALE_EN) begin : g_stop_chk
            p_force_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_wr && (wr_data[2:0] == 3'b111 || wr_data[2:0] == 3'b001))
                |=> stopped_q);
        end
    endgenerate

endmodule

// File: tb/gated_timer_channel_tb.sv
module gated_timer_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        gate_in = 1'b0;
    logic        tick_in = 1'b0;
    logic [15:0] count_o;
    logic [15:0] mode_o;
    logic        stopped_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .gate_in(gate_in), .tick_in(tick_in),
        .count_o(count_o), .mode_o(mode_o), .stopped_o(stopped_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;

    // Reference model state, built from the requirements.
    logic        m_g1 = 0, m_g2 = 0, m_g3 = 0, m_t1 = 0, m_t2 = 0, m_t3 = 0;
    logic [15:0] m_mode = '0, m_cnt = '0;
    logic        m_stop = 1'b0;
    int          m_phase = 0;

    function automatic int ratio(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 16;
            default: return 256;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic gs, ge, tr, clr, hold, nstop, inc, alt, gen;
        int   div;
        logic [1:0] gm;
        gs = m_g2 & ~m_g3;
        ge = ~m_g2 & m_g3;
        tr = m_t2 & ~m_t3;
        if (!rst_n) begin
            {m_g1, m_g2, m_g3, m_t1, m_t2, m_t3} = '0;
            m_mode = '0; m_cnt = '0; m_stop = 1'b0; m_phase = 0;
        end else begin
            m_g3 = m_g2; m_g2 = m_g1; m_g1 = gate_in;
            m_t3 = m_t2; m_t2 = m_t1; m_t1 = tick_in;
            div = ratio(m_mode[14:13]);
            alt = m_mode[8];
            gen = m_mode[0];
            gm  = m_mode[2:1];
            if (wr_en && !wr_sel) begin
                m_mode  = wr_data | 16'h0400;
                m_cnt   = '0;
                m_phase = 0;
                m_stop  = (wr_data[8] && wr_data[0]) ||
                          (wr_data[2:0] == 3'b111) || (wr_data[2:0] == 3'b001);
            end else if (wr_en && wr_sel) begin
                m_cnt = wr_data;
                if (!m_stop && !alt) m_phase = (m_phase == div - 1) ? 0 : m_phase + 1;
            end else begin
                clr = 0; hold = 0; nstop = m_stop;
                if (gen) begin
                    case (gm)
                        2'd0: begin
                            if (gs) begin hold = 1; nstop = 1; end
                            if (ge) begin clr = 1; nstop = 0; end
                        end
                        2'd1: if (ge) clr = 1;
                        2'd2: begin
                            if (gs) begin clr = 1; nstop = 0; end
                            if (ge) begin hold = 1; nstop = 1; end
                        end
                        default: if (ge && m_stop) begin clr = 1; nstop = 0; end
                    endcase
                end
                inc = !m_stop && (alt ? tr : (m_phase == div - 1));
                if (clr) m_cnt = '0;
                else if (inc && !hold) m_cnt = m_cnt + 16'd1;
                if (clr) m_phase = 0;
                else if (!m_stop && !alt) m_phase = (m_phase == div - 1) ? 0 : m_phase + 1;
                m_stop = nstop;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, "count", 32'(count_o), 32'(m_cnt));
            chk(cur_req, "stopped", 32'(stopped_o), 32'(m_stop));
            chk(cur_req, "mode", 32'(mode_o), 32'(m_mode));
        end
    end

    task automatic step(input logic g, input logic t);
        @(negedge clk);
        wr_en = 1'b0; gate_in = g; tick_in = t;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d, input logic g, input logic t);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; gate_in = g; tick_in = t;
    endtask

    function automatic logic [15:0] mk_mode(input int pre, input int alt, input int gm, input int gen);
        return 16'((pre << 13) | (alt << 8) | (gm << 1) | gen);
    endfunction

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset count", 32'(count_o), 0);
        chk("R1", "reset stopped", 32'(stopped_o), 0);
        chk("R1", "reset mode", 32'(mode_o), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (20) step(0, 0);

        // Sweep over divide ratio, source, gate behaviour and gate enable.
        for (int cfg = 0; cfg < 64; cfg++) begin
            int pre, alt, gm, gen, off;
            logic g;
            pre = cfg / 16; alt = (cfg / 8) % 2; gm = (cfg / 2) % 4; gen = cfg % 2;
            off = cfg % 7;
            if (gen != 0) begin
                case (gm)
                    0: cur_req = "R8 R13";
                    1: cur_req = "R9 R13";
                    2: cur_req = "R10 R13";
                    default: cur_req = "R11 R13";
                endcase
            end else if (alt != 0) cur_req = "R3 R12";
            else cur_req = "R2 R12";
            g = 1'b0;
            wr(0, mk_mode(pre, alt, gm, gen), 0, 0);
            for (int c = 0; c < 600; c++) begin
                if (c == 30 + off || c == 200 + off || c == 330 + off || c == 470 + off) g = ~g;
                if (c == 260) wr(1, 16'hFFFE, g, 1'((c / 3) % 2));
                else step(g, 1'((c / 3) % 2));
            end
            repeat (4) step(0, 0);
        end

        // R4: stored word carries the forced flag, count cleared.
        cur_req = "R4";
        wr(0, 16'h2000, 0, 0);
        step(0, 0);
        chk("R4", "mode readback", 32'(mode_o), 32'h2400);
        chk("R4", "count cleared", 32'(count_o), 0);

        // R7: load mid-phase at ratio 8; increment keeps its phase.
        cur_req = "R7";
        step(0, 0);
        wr(1, 16'd100, 0, 0);
        step(0, 0);
        chk("R7", "count loaded", 32'(count_o), 100);
        repeat (4) step(0, 0);
        chk("R7", "no early increment", 32'(count_o), 100);
        step(0, 0);
        chk("R7", "increment on phase", 32'(count_o), 101);

        // R5: alternate source with gating starts stopped.
        cur_req = "R5";
        wr(0, 16'h0105, 0, 0);
        step(0, 0);
        chk("R5", "stopped", 32'(stopped_o), 1);

        // R6: forbidden gate settings on the prescaled variant.
        cur_req = "R6";
        wr(0, 16'h0001, 0, 0);
        step(0, 0);
        chk("R6", "low 001 stops", 32'(stopped_o), 1);
        wr(0, 16'h0007, 0, 0);
        step(0, 0);
        chk("R6", "low 111 stops", 32'(stopped_o), 1);
        wr(0, 16'h0003, 0, 0);
        step(0, 0);
        chk("R6", "low 011 runs", 32'(stopped_o), 0);

        // R13: count write lands on the edge of a gate-end clear.
        cur_req = "R13";
        repeat (6) step(1, 0);
        step(0, 0);
        step(0, 0);
        wr(1, 16'h0055, 0, 0);
        step(0, 0);
        chk("R13", "write beats gate clear", 32'(count_o), 32'h0055);
        repeat (4) step(0, 0);

        cmp_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule